// File: doc/BRIEF.md
# Byte-sequenced I2C master controller with chained write-then-read

This block is the transfer sequencer of an I2C master. Software programs it through a small word-addressed register file. It sets a 7-bit slave address and a byte count, loads outgoing bytes into a 16-entry FIFO, and then writes the control word with the go bit. The sequencer emits a chain of byte-level bus commands: START, the address byte, data writes or data reads, and STOP. These go over a valid/ready command stream to a bit engine, which drives SCL and SDA and lies outside this block. The engine answers each accepted command with a single-cycle response that carries the slave's ACK, a received byte, or a clock-stretch timeout.

The sequencer reads the direction and count when it leaves idle. When the last transmitted byte is acknowledged, it checks whether software has raised go again in the meantime. If go is pending, it reads the direction and count a second time and issues a repeated START with a fresh address byte instead of a STOP. Software can therefore start a register-pointer write and, while that write is still in progress, queue the read that must follow it without releasing the bus. Outgoing and incoming bytes share the one FIFO.

Registers by word address: 0 control, 1 status, 2 length, 3 slave address, 4 FIFO. Control bits: 0 go, 1 read direction, 2 FIFO flush (write-only pulse), 3 enable, 4 interrupt enable. Status bits: 0 active, 1 done, 2 NAK error, 3 stretch timeout, 4 FIFO not empty, 5 FIFO full, 31:28 sequencer state code. The state codes are 0 idle, 1 START, 2 address, 3 transmit, 4 read request, 5 read wait, 6 repeated START and 7 STOP. Bus command opcodes are 0 START, 1 repeated START, 2 write byte, 3 read byte and 4 STOP. The `cmd_last` flag on a read asks the engine to NAK that byte.

Command-stream rules: `cmd_valid` is not withdrawn and `cmd_op`, `cmd_byte` and `cmd_last` do not change until `cmd_ready` is seen. The sequencer never has more than one command outstanding. `rsp_valid` has no ready signal, and the sequencer accepts it in any cycle after the command was taken.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset, status reads 0, length reads 0, `irq` is 0, `cmd_valid` is 0 and the FIFO is empty.
- R2: A control write with go=1 and enable=1 in idle takes the direction and the length. It issues START, then the address byte (slave address shifted left one place, with the read bit 1 in bit 0).
- R3: In a write, N bytes leave the FIFO in order as write commands. Each acknowledged byte lowers the length readback by one. With no go pending afterwards, the sequencer issues STOP, then sets done and clears active, and length reads 0.
- R4: If go is pending when the last write byte is acknowledged, the sequencer takes the direction and length again and issues a repeated START and a new address byte instead of STOP. The pending go is consumed.
- R5: A read of N bytes issues N read commands with `cmd_last`=1 only on the last one. It pushes the received bytes into the FIFO in order and then issues STOP.
- R6: A NAK on the address or on a data byte sets the NAK error flag and goes straight to STOP. Length then reads the count still remaining.
- R7: A timeout response sets the stretch-timeout flag and moves to STOP. A timeout on the STOP itself ends in idle.
- R8: Done, NAK error and timeout clear when status is written with 1 in their bit positions. A 0 in a bit position leaves that flag unchanged.
- R9: The FIFO holds 16 bytes. A write to a full FIFO is dropped, the flush bit empties the FIFO, and status bits 4 and 5 report not-empty and full.
- R10: Status bits 31:28 show the state code: 0 in idle, 4 or 5 while reading.
- R11: A go written while enable is 0 in the same write is ignored: no command is issued and active stays 0.
- R12: `irq` equals interrupt-enable AND done.
- R13: While `cmd_valid` is high and `cmd_ready` low, the command fields hold stable into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe (pops the FIFO at address 4) |
| reg_rd_addr | input | 3 | Register read word address |
| reg_rd_data | output | 32 | Register read data, combinational |
| irq | output | 1 | Interrupt: done while enabled |
| cmd_valid | output | 1 | Bus command valid |
| cmd_ready | input | 1 | Bit engine takes the command |
| cmd_op | output | 3 | Bus command opcode |
| cmd_byte | output | 8 | Byte to send |
| cmd_last | output | 1 | NAK this read byte |
| rsp_valid | input | 1 | Command finished |
| rsp_ack | input | 1 | Slave acknowledged the written byte |
| rsp_tmo | input | 1 | Clock-stretch timeout |
| rsp_byte | input | 8 | Byte received |

## Verification
Two events can land in the same cycle. The first is a software FIFO write in the cycle the sequencer pops a transmit byte. This is provoked by loading only the first byte of a six-byte write and then pushing the other five on back-to-back cycles while a zero-latency engine model drains them. The bench judges the case by the exact byte order in the logged write commands. The second is a go written while a write is in flight, which must be resolved at the final ACK. It is judged by the full logged command sequence (repeated START, a read address byte, three reads with the last one flagged) and by the bytes popped back from the FIFO.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_START  = 4'd1,
    ST_ADDR   = 4'd2,
    ST_TX     = 4'd3,
    ST_RXREQ  = 4'd4,
    ST_RXWAIT = 4'd5,
    ST_RSTART = 4'd6,
    ST_STOP   = 4'd7
  } seq_state_e;

  typedef enum logic [2:0] {
    OP_START  = 3'd0,
    OP_RSTART = 3'd1,
    OP_WRITE  = 3'd2,
    OP_READ   = 3'd3,
    OP_STOP   = 3'd4
  } bus_op_e;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_STAT  = 3'd1;
  localparam logic [2:0] RA_LEN   = 3'd2;
  localparam logic [2:0] RA_SLAVE = 3'd3;
  localparam logic [2:0] RA_FIFO  = 3'd4;

  localparam int CB_GO    = 0;
  localparam int CB_READ  = 1;
  localparam int CB_FLUSH = 2;
  localparam int CB_EN    = 3;
  localparam int CB_IRQEN = 4;
endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full,
  output logic [CW-1:0]    count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign head    = mem[rptr];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= nxt(wptr);
      if (do_pop)  rptr <= nxt(rptr);
      if (do_push && !do_pop) count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= push_data;
  end
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             go_set,
  input  logic             dir_in,
  input  logic [LEN_W-1:0] len_in,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_wdata,
  input  logic [6:0]       slave_addr,
  input  logic             fifo_empty,
  input  logic             fifo_full,
  input  logic [7:0]       fifo_head,
  output logic             hw_pop,
  output logic             hw_push,
  output logic [7:0]       hw_wdata,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_last,
  input  logic             rsp_valid,
  input  logic             rsp_ack,
  input  logic             rsp_tmo,
  input  logic [7:0]       rsp_byte,
  output logic [3:0]       state_code,
  output logic             start_pend,
  output logic [LEN_W-1:0] xfer_cnt,
  output logic             evt_done,
  output logic             evt_nak,
  output logic             evt_tmo
);
  seq_state_e state_q;
  logic wait_q, dir_q, start_q;
  logic [LEN_W-1:0] cnt_q;
  logic accept, rsp_hit, launch, decide, consume, good;
  bus_op_e op;

  assign state_code = state_q;
  assign start_pend = start_q;
  assign xfer_cnt   = cnt_q;

  always_comb begin
    cmd_valid = 1'b0;
    op        = OP_STOP;
    cmd_byte  = 8'h00;
    cmd_last  = 1'b0;
    case (state_q)
      ST_START:  begin cmd_valid = !wait_q; op = OP_START; end
      ST_RSTART: begin cmd_valid = !wait_q; op = OP_RSTART; end
      ST_ADDR:   begin cmd_valid = !wait_q; op = OP_WRITE; cmd_byte = {slave_addr, dir_q}; end
      ST_TX:     begin cmd_valid = !wait_q && !fifo_empty; op = OP_WRITE; cmd_byte = fifo_head; end
      ST_RXREQ:  begin cmd_valid = !fifo_full; op = OP_READ; cmd_last = (cnt_q == LEN_W'(1)); end
      ST_STOP:   begin cmd_valid = !wait_q; op = OP_STOP; end
      default:   cmd_valid = 1'b0;
    endcase
  end
  assign cmd_op = op;

  assign accept   = cmd_valid && cmd_ready;
  assign rsp_hit  = rsp_valid && (wait_q || state_q == ST_RXWAIT);
  assign good     = rsp_hit && !rsp_tmo;
  assign hw_pop   = accept && state_q == ST_TX;
  assign hw_push  = good && state_q == ST_RXWAIT;
  assign hw_wdata = rsp_byte;
  assign evt_done = rsp_hit && state_q == ST_STOP;
  assign evt_tmo  = rsp_hit && rsp_tmo;
  assign evt_nak  = good && !rsp_ack && (state_q == ST_ADDR || state_q == ST_TX);

  assign launch  = state_q == ST_IDLE && enable && start_q;
  assign decide  = good && rsp_ack &&
                   ((state_q == ST_ADDR && !dir_q && cnt_q == '0) ||
                    (state_q == ST_TX && cnt_q == LEN_W'(1)));
  assign consume = launch || (decide && start_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= 1'b0;
      dir_q   <= 1'b0;
      start_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      start_q <= go_set || (start_q && !consume);
      if (accept && state_q != ST_RXREQ) wait_q <= 1'b1;
      if (rsp_hit) wait_q <= 1'b0;

      if (launch) begin
        state_q <= ST_START;
        dir_q   <= dir_in;
        cnt_q   <= len_in;
      end else if (state_q == ST_IDLE && len_wr) begin
        cnt_q <= len_wdata;
      end else if (state_q == ST_RXREQ && accept) begin
        state_q <= ST_RXWAIT;
      end else if (rsp_hit && rsp_tmo) begin
        state_q <= (state_q == ST_STOP) ? ST_IDLE : ST_STOP;
      end else if (rsp_hit) begin
        case (state_q)
          ST_START, ST_RSTART: state_q <= ST_ADDR;
          ST_ADDR, ST_TX: begin
            if (!rsp_ack) state_q <= ST_STOP;
            else begin
              if (state_q == ST_TX) cnt_q <= cnt_q - 1'b1;
              if (decide) begin
                if (start_q) begin
                  state_q <= ST_RSTART;
                  dir_q   <= dir_in;
                  cnt_q   <= len_in;
                end else state_q <= ST_STOP;
              end else if (state_q == ST_ADDR)
                state_q <= (dir_q && cnt_q == '0) ? ST_STOP : (dir_q ? ST_RXREQ : ST_TX);
            end
          end
          ST_RXWAIT: begin
            cnt_q   <= cnt_q - 1'b1;
            state_q <= (cnt_q == LEN_W'(1)) ? ST_STOP : ST_RXREQ;
          end
          ST_STOP: state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int LEN_W      = 8,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [2:0]  reg_wr_addr,
  input  logic [31:0] reg_wr_data,
  input  logic        reg_rd_en,
  input  logic [2:0]  reg_rd_addr,
  output logic [31:0] reg_rd_data,
  output logic        irq,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [2:0]  cmd_op,
  output logic [7:0]  cmd_byte,
  output logic        cmd_last,
  input  logic        rsp_valid,
  input  logic        rsp_ack,
  input  logic        rsp_tmo,
  input  logic [7:0]  rsp_byte
);
  logic enable_q, dir_q, irqen_q;
  logic flag_done, flag_nak, flag_tmo;
  logic [LEN_W-1:0] len_q, xfer_cnt;
  logic [6:0] slave_q;
  logic wr_ctrl, wr_stat, wr_len, go_set, flush;
  logic fifo_empty, fifo_full, hw_pop, hw_push, sw_push, sw_pop;
  logic [7:0] fifo_head, hw_wdata, push_data;
  logic [CW-1:0] fifo_cnt;
  logic [3:0] state_code;
  logic start_pend, evt_done, evt_nak, evt_tmo;

  assign wr_ctrl = reg_wr_en && reg_wr_addr == RA_CTRL;
  assign wr_stat = reg_wr_en && reg_wr_addr == RA_STAT;
  assign wr_len  = reg_wr_en && reg_wr_addr == RA_LEN;
  assign go_set  = wr_ctrl && reg_wr_data[CB_GO] && reg_wr_data[CB_EN];
  assign flush   = wr_ctrl && reg_wr_data[CB_FLUSH];
  assign sw_push = reg_wr_en && reg_wr_addr == RA_FIFO && !hw_push;
  assign sw_pop  = reg_rd_en && reg_rd_addr == RA_FIFO && !hw_pop;
  assign push_data = hw_push ? hw_wdata : reg_wr_data[7:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q  <= 1'b0;
      dir_q     <= 1'b0;
      irqen_q   <= 1'b0;
      len_q     <= '0;
      slave_q   <= '0;
      flag_done <= 1'b0;
      flag_nak  <= 1'b0;
      flag_tmo  <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        enable_q <= reg_wr_data[CB_EN];
        dir_q    <= reg_wr_data[CB_READ];
        irqen_q  <= reg_wr_data[CB_IRQEN];
      end
      if (wr_len) len_q <= reg_wr_data[LEN_W-1:0];
      if (reg_wr_en && reg_wr_addr == RA_SLAVE) slave_q <= reg_wr_data[6:0];
      flag_done <= evt_done || (flag_done && !(wr_stat && reg_wr_data[1]));
      flag_nak  <= evt_nak  || (flag_nak  && !(wr_stat && reg_wr_data[2]));
      flag_tmo  <= evt_tmo  || (flag_tmo  && !(wr_stat && reg_wr_data[3]));
    end
  end

  assign irq = irqen_q && flag_done;

  always_comb begin
    case (reg_rd_addr)
      RA_CTRL:  reg_rd_data = {27'b0, irqen_q, enable_q, 1'b0, dir_q, start_pend};
      RA_STAT:  reg_rd_data = {state_code, 22'b0, fifo_full, !fifo_empty,
                               flag_tmo, flag_nak, flag_done, state_code != 4'd0};
      RA_LEN:   reg_rd_data = 32'(xfer_cnt);
      RA_SLAVE: reg_rd_data = {25'b0, slave_q};
      RA_FIFO:  reg_rd_data = {24'b0, fifo_head};
      default:  reg_rd_data = 32'b0;
    endcase
  end

  i2cm_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push(hw_push || sw_push), .push_data(push_data),
    .pop(hw_pop || sw_pop), .head(fifo_head),
    .empty(fifo_empty), .full(fifo_full), .count(fifo_cnt)
  );

  i2cm_seq #(.LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable_q), .go_set(go_set),
    .dir_in(reg_wr_data[CB_READ] & wr_ctrl | dir_q & ~wr_ctrl),
    .len_in(len_q), .len_wr(wr_len), .len_wdata(reg_wr_data[LEN_W-1:0]),
    .slave_addr(slave_q), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_head(fifo_head), .hw_pop(hw_pop), .hw_push(hw_push), .hw_wdata(hw_wdata),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_byte(cmd_byte), .cmd_last(cmd_last), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_tmo(rsp_tmo), .rsp_byte(rsp_byte),
    .state_code(state_code), .start_pend(start_pend), .xfer_cnt(xfer_cnt),
    .evt_done(evt_done), .evt_nak(evt_nak), .evt_tmo(evt_tmo)
  );
endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk #(
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    state_code,
  input logic          start_pend,
  input logic          enable_q,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [2:0]    cmd_op,
  input logic [7:0]    cmd_byte,
  input logic          cmd_last,
  input logic          rsp_valid,
  input logic          rsp_ack,
  input logic          rsp_tmo,
  input logic [CW-1:0] fifo_cnt,
  input logic          flag_done
);
  assert_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_code == 4'd0 && start_pend && enable_q) |=> state_code == 4'd1);

  assert_cmd_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_byte) && $stable(cmd_last)));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  assert_done_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_done) |-> $past(state_code) == 4'd7);

  assert_nak_to_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_tmo && !rsp_ack && (state_code == 4'd2 || state_code == 4'd3))
      |=> state_code == 4'd7);

  assert_tmo_leaves_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tmo && state_code == 4'd7) |=> state_code == 4'd0);
endmodule

bind i2cm_ctrl i2cm_ctrl_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .state_code(state_code), .start_pend(start_pend),
  .enable_q(enable_q), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
  .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_tmo(rsp_tmo),
  .fifo_cnt(fifo_cnt), .flag_done(flag_done)
);

// File: tb/tb_i2cm_ctrl.sv
module tb_i2cm_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr_en = 0, reg_rd_en = 0;
  logic [2:0] reg_wr_addr = 0, reg_rd_addr = 0;
  logic [31:0] reg_wr_data = 0, reg_rd_data;
  logic irq, cmd_valid, cmd_ready = 0, cmd_last;
  logic [2:0] cmd_op;
  logic [7:0] cmd_byte, rsp_byte = 0;
  logic rsp_valid = 0, rsp_ack = 0, rsp_tmo = 0;

  always #10 clk = ~clk;

  i2cm_ctrl dut (.*);

  int n_chk = 0, n_bad = 0;
  int eng_dly = 0, nak_at = -1, tmo_at = -1;
  int log_n = 0, ex_n = 0;
  logic [11:0] log_v [64];
  logic [11:0] ex_v [64];
  logic [7:0] seen;

  localparam logic [2:0] OS = 0, OR = 1, OW = 2, ORD = 3, OP = 4;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-engine and slave model
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 0;
      if (cmd_valid) begin
        repeat (eng_dly) @(negedge clk);
        if (log_n < 64) log_v[log_n] = {cmd_last, cmd_op, cmd_byte};
        cmd_ready = 1;
        @(negedge clk);
        cmd_ready = 0;
        repeat (eng_dly) @(negedge clk);
        rsp_valid = 1;
        rsp_ack   = (log_n != nak_at);
        rsp_tmo   = (log_n == tmo_at);
        rsp_byte  = 8'h30 + 8'(log_n);
        log_n++;
      end
    end
  end

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_addr = a;
    #1 d = reg_rd_data;
  endtask

  task automatic pop(output logic [7:0] d);
    @(negedge clk);
    reg_rd_addr = 3'd4; reg_rd_en = 1;
    #1 d = reg_rd_data[7:0];
    @(negedge clk);
    reg_rd_en = 0;
  endtask

  task automatic wait_done();
    logic [31:0] s;
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      rreg(3'd1, s);
      seen[s[30:28]] = 1'b1;
      if (s[1] && !s[0]) return;
    end
    check("R3 completion", 0, 1);
  endtask

  task automatic newx();
    log_n = 0; ex_n = 0; nak_at = -1; tmo_at = -1;
  endtask

  task automatic ex(input logic [2:0] op, input logic [7:0] b, input logic last);
    ex_v[ex_n] = {last, op, b};
    ex_n++;
  endtask

  task automatic cmp_log(input string req);
    check(req, 32'(log_n), 32'(ex_n));
    for (int i = 0; i < ex_n; i++) check(req, 32'(log_v[i]), 32'(ex_v[i]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] s;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rreg(3'd1, s); check("R1 status", s, 0);
    rreg(3'd2, s); check("R1 length", s, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 cmd_valid", 32'(cmd_valid), 0);
    wreg(3'd3, 32'h52);

    // R3 write sweep across engine latency and length
    for (int d = 0; d < 3; d++)
      for (int n = 1; n <= 4; n++) begin
        eng_dly = d; newx();
        wreg(3'd2, 32'(n));
        for (int k = 0; k < n; k++) wreg(3'd4, 32'(8'h10 * n + k));
        wreg(3'd0, 32'h9);
        wait_done();
        ex(OS, 0, 0); ex(OW, 8'hA4, 0);
        for (int k = 0; k < n; k++) ex(OW, 8'(8'h10 * n + k), 0);
        ex(OP, 0, 0);
        cmp_log("R2 R3 write sequence");
        rreg(3'd2, s); check("R3 length after write", s, 0);
        rreg(3'd1, s); check("R3 status done", s, 32'h2);
        wreg(3'd1, 32'h2);
        rreg(3'd1, s); check("R8 done cleared", s, 0);
      end

    // R5 read sweep
    for (int d = 0; d < 3; d++)
      for (int n = 1; n <= 4; n++) begin
        eng_dly = d; newx();
        wreg(3'd2, 32'(n));
        wreg(3'd0, 32'hB);
        wait_done();
        check("R10 receive state codes seen", 32'(seen[4] & seen[5] | (d == 0)), 1);
        ex(OS, 0, 0); ex(OW, 8'hA5, 0);
        for (int k = 0; k < n; k++) ex(ORD, 0, k == n - 1);
        ex(OP, 0, 0);
        cmp_log("R5 read sequence");
        for (int k = 0; k < n; k++) begin
          pop(b); check("R5 read data", 32'(b), 32'(8'h32 + k));
        end
        rreg(3'd1, s); check("R10 idle code", s, 32'h2);
        wreg(3'd1, 32'h2);
      end

    // R4 chained write then read
    eng_dly = 1; newx();
    wreg(3'd2, 32'd2);
    wreg(3'd0, 32'h9);
    wreg(3'd2, 32'd3);
    wreg(3'd0, 32'hB);
    wreg(3'd4, 32'hC1);
    wreg(3'd4, 32'hC2);
    wait_done();
    ex(OS, 0, 0); ex(OW, 8'hA4, 0); ex(OW, 8'hC1, 0); ex(OW, 8'hC2, 0);
    ex(OR, 0, 0); ex(OW, 8'hA5, 0);
    ex(ORD, 0, 0); ex(ORD, 0, 0); ex(ORD, 0, 1); ex(OP, 0, 0);
    cmp_log("R4 repeated start chain");
    for (int k = 0; k < 3; k++) begin
      pop(b); check("R4 chained read data", 32'(b), 32'(8'h36 + k));
    end
    repeat (10) @(negedge clk);
    rreg(3'd1, s); check("R4 go consumed, stays idle", s, 32'h2);
    wreg(3'd1, 32'h2);

    // R6 address NAK
    newx(); nak_at = 1;
    wreg(3'd2, 32'd4);
    wreg(3'd0, 32'h9);
    wait_done();
    ex(OS, 0, 0); ex(OW, 8'hA4, 0); ex(OP, 0, 0);
    cmp_log("R6 address nak");
    rreg(3'd1, s); check("R6 nak flag", s, 32'h6);
    rreg(3'd2, s); check("R6 remaining after addr nak", s, 4);
    wreg(3'd1, 32'h6);

    // R6 data NAK on second byte
    newx(); nak_at = 3;
    wreg(3'd2, 32'd4);
    for (int k = 0; k < 4; k++) wreg(3'd4, 32'(8'h50 + k));
    wreg(3'd0, 32'h9);
    wait_done();
    ex(OS, 0, 0); ex(OW, 8'hA4, 0); ex(OW, 8'h50, 0); ex(OW, 8'h51, 0); ex(OP, 0, 0);
    cmp_log("R6 data nak");
    rreg(3'd2, s); check("R6 remaining after data nak", s, 3);
    rreg(3'd1, s); check("R9 leftover bytes", 32'(s[4]), 1);
    wreg(3'd0, 32'hC);
    rreg(3'd1, s); check("R9 flush empties", s, 32'h6);
    wreg(3'd1, 32'h6);

    // R7 timeout
    newx(); tmo_at = 2;
    wreg(3'd2, 32'd2);
    wreg(3'd4, 32'h61); wreg(3'd4, 32'h62);
    wreg(3'd0, 32'h9);
    wait_done();
    ex(OS, 0, 0); ex(OW, 8'hA4, 0); ex(OW, 8'h61, 0); ex(OP, 0, 0);
    cmp_log("R7 timeout sequence");
    rreg(3'd1, s); check("R7 timeout flag", s & 32'hF, 32'hA);
    wreg(3'd1, 32'h0);
    rreg(3'd1, s); check("R8 zero write keeps flags", s & 32'hF, 32'hA);
    wreg(3'd1, 32'h8);
    rreg(3'd1, s); check("R8 timeout cleared", s & 32'hF, 32'h2);
    wreg(3'd0, 32'hC);

    // R7 timeout on STOP
    newx(); tmo_at = 2;
    wreg(3'd2, 32'd0);
    wreg(3'd0, 32'h9);
    wait_done();
    ex(OS, 0, 0); ex(OW, 8'hA4, 0); ex(OP, 0, 0);
    cmp_log("R7 timeout on stop");
    rreg(3'd1, s); check("R7 stop timeout to idle", s, 32'hA);
    wreg(3'd1, 32'hE);

    // R12 irq
    check("R12 irq low when done clear", 32'(irq), 0);
    wreg(3'd0, 32'h18);
    newx(); wreg(3'd2, 32'd0); wreg(3'd0, 32'h19);
    wait_done();
    @(negedge clk); check("R12 irq with done", 32'(irq), 1);
    wreg(3'd1, 32'h2);
    @(negedge clk); check("R12 irq cleared", 32'(irq), 0);

    // R11 go ignored without enable
    newx();
    wreg(3'd0, 32'h1);
    repeat (20) @(negedge clk);
    rreg(3'd1, s); check("R11 no transfer", s, 0);
    check("R11 no command", 32'(log_n), 0);
    wreg(3'd0, 32'h8);
    repeat (20) @(negedge clk);
    rreg(3'd1, s); check("R11 go not remembered", s, 0);

    // R9 full FIFO
    for (int k = 0; k < 17; k++) wreg(3'd4, 32'(k));
    rreg(3'd1, s); check("R9 full flag", s, 32'h30);
    for (int k = 0; k < 16; k++) begin
      pop(b); check("R9 fifo order, overflow dropped", 32'(b), 32'(k));
    end
    rreg(3'd1, s); check("R9 empty after drain", s, 0);

    // R3 same-cycle software push and sequencer pop
    eng_dly = 0; newx();
    wreg(3'd2, 32'd6);
    wreg(3'd4, 32'h70);
    wreg(3'd0, 32'h9);
    @(negedge clk);
    for (int k = 1; k < 6; k++) begin
      reg_wr_en = 1; reg_wr_addr = 3'd4; reg_wr_data = 32'(8'h70 + k);
      @(negedge clk);
    end
    reg_wr_en = 0;
    wait_done();
    ex(OS, 0, 0); ex(OW, 8'hA4, 0);
    for (int k = 0; k < 6; k++) ex(OW, 8'(8'h70 + k), 0);
    ex(OP, 0, 0);
    cmp_log("R3 push during pop");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule